// File: doc/BRIEF.md
# System Clock Switch with Failure Fallback

This block picks the system clock from four oscillators: a low-speed internal RC, a low-speed crystal, a divided high-speed internal RC and a high-speed crystal. Software writes a target source. The switch happens only once the target reports ready. A glitch-free gating network turns the old clock off on its own falling edge before it turns the new one on. A status field reports the source that actually drives the output. Software can enable or disable each oscillator, but a request to stop the source in use, or the one being switched to, has no effect.

Two window monitors watch for a stopped clock. Each runs on the always-present reference clock `clk`. The monitor for the high-speed crystal runs when software enables it and the crystal is both enabled and ready. When that crystal fails, the block disables it, issues a one-cycle break pulse, sets a sticky interrupt and falls back to the internal high-speed source. The monitor for the low-speed crystal is armed by a set-only enable. When that crystal fails, the block disables it, clears the enable, sets its own sticky interrupt and falls back to the low-speed RC.

Top module: `sysclk_switch`

## Requirements
- R1: Out of reset the selection status is 2 (internal high-speed source), only that oscillator is enabled (`osc_en` = 4'b0100), both interrupts and the low-speed monitor enable are 0, and `sys_clk` runs at the raw internal high-speed clock divided by `HSI_DIV` (4). Source codes are 0 low-speed RC, 1 low-speed crystal, 2 divided internal high-speed, 3 high-speed crystal, and bit i of every 4-bit vector belongs to source i.
- R2: Writing a target whose oscillator is enabled and ready makes `sel_status` equal that code, and makes `sys_clk` run at that source's period.
- R3: If the target is not ready, `sel_status` and `sys_clk` keep the previous source. The switch completes without a further write once the target becomes ready.
- R4: `osc_on` bits enable oscillators and `osc_off` bits disable them. An off request for the active source (or the pending one) is ignored.
- R5: The high-speed crystal monitor is armed only while `hse_mon_en` is 1 and that crystal is enabled and ready. A stopped crystal with the monitor off raises nothing.
- R6: On a high-speed crystal failure (no edge within `FAIL_WIN` reference cycles), `osc_en[3]` clears, `fail_brk` pulses for one cycle, and `hse_fail_irq` sets. If the crystal was in use, the selection falls back to code 2.
- R7: `hse_fail_irq` stays set until `hse_irq_clr` is pulsed.
- R8: On a low-speed crystal failure while it is in use, the selection falls back to code 0, `osc_en[1]` clears and `lse_fail_irq` sets and holds until `lse_irq_clr`. No break pulse is issued.
- R9: `lse_mon_on` is set by `lse_mon_set` and is cleared only by reset or a detected low-speed crystal failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference and control clock |
| rst | input | 1 | Synchronous active-high reset |
| lsi_clk | input | 1 | Low-speed RC oscillator clock |
| lse_clk | input | 1 | Low-speed crystal clock |
| hsi_clk | input | 1 | Raw internal high-speed clock (divided inside) |
| hse_clk | input | 1 | High-speed crystal clock |
| osc_rdy | input | 4 | Per-source ready indications |
| osc_on | input | 4 | Per-source enable requests (one-cycle pulses) |
| osc_off | input | 4 | Per-source disable requests (one-cycle pulses) |
| sel_wr | input | 1 | Write strobe for the target selection |
| sel_val | input | 2 | Requested source code |
| hse_mon_en | input | 1 | Enable for the high-speed crystal monitor |
| lse_mon_set | input | 1 | Sets the low-speed crystal monitor enable |
| hse_irq_clr | input | 1 | Clears the high-speed failure interrupt |
| lse_irq_clr | input | 1 | Clears the low-speed failure interrupt |
| osc_en | output | 4 | Oscillator enables |
| sel_status | output | 2 | Source actually driving `sys_clk` |
| sys_clk | output | 1 | Glitch-free selected system clock |
| hse_fail_irq | output | 1 | Sticky high-speed crystal failure interrupt |
| lse_fail_irq | output | 1 | Sticky low-speed crystal failure interrupt |
| fail_brk | output | 1 | One-cycle break pulse on high-speed crystal failure |
| lse_mon_on | output | 1 | Low-speed crystal monitor enable |

## Verification
The bench uses the defaults `HSI_DIV` = 4, `FAIL_WIN` = 8 and `SYNC_STAGES` = 2. The four oscillator periods (40, 50, 16 after division, and 14 ns) are all distinct and no shorter than the reference period. That lets each selection be confirmed by measuring the period of `sys_clk`, and lets both monitors see every edge of a running clock. The short eight-cycle window makes a stopped crystal show up within a few dozen reference cycles. Both fallbacks, the disarmed-monitor case and the sticky flags can therefore be reached in a short run next to randomized switch sequences.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NSRC = 4;

  typedef enum logic [1:0] {
    SRC_LSI = 2'd0,
    SRC_LSE = 2'd1,
    SRC_HSI = 2'd2,
    SRC_HSE = 2'd3
  } src_e;

  function automatic logic [NSRC-1:0] src_bit(input src_e s);
    logic [NSRC-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clk_div_pow2.sv
module clk_div_pow2 #(
  parameter int DIV = 4
) (
  input  logic clk_in,
  input  logic clr,
  output logic clk_out
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk_in or posedge clr) begin
    if (clr) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign clk_out = cnt[W-1];
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic clr,
  input  logic want,
  output logic gate,
  output logic clk_out
);
  logic [SYNC_STAGES-1:0] sh;

  always_ff @(posedge clk_src or posedge clr) begin
    if (clr) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-2:0], want};
  end

  // enable changes only while the source clock is low
  always_ff @(negedge clk_src or posedge clr) begin
    if (clr) gate <= 1'b0;
    else     gate <= sh[SYNC_STAGES-1];
  end

  assign clk_out = clk_src & gate;
endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon #(
  parameter int WIN         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_clk,
  input  logic mon_clr,
  input  logic arm,
  output logic fail
);
  localparam int CW = $clog2(WIN + 1);

  logic                 tgl;
  logic [SYNC_STAGES:0] sy;
  logic [CW-1:0]        cnt;
  logic                 seen;

  always_ff @(posedge mon_clk or posedge mon_clr) begin
    if (mon_clr) tgl <= 1'b0;
    else         tgl <= ~tgl;
  end

  always_ff @(posedge clk) begin
    if (rst) sy <= '0;
    else     sy <= {sy[SYNC_STAGES-1:0], tgl};
  end

  assign seen = sy[SYNC_STAGES] ^ sy[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      cnt  <= '0;
      fail <= 1'b0;
    end else begin
      fail <= 1'b0;
      if (seen) begin
        cnt <= '0;
      end else if (cnt == CW'(WIN - 1)) begin
        fail <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int HSI_DIV     = 4,
  parameter int FAIL_WIN    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lsi_clk,
  input  logic            lse_clk,
  input  logic            hsi_clk,
  input  logic            hse_clk,
  input  logic [NSRC-1:0] osc_rdy,
  input  logic [NSRC-1:0] osc_on,
  input  logic [NSRC-1:0] osc_off,
  input  logic            sel_wr,
  input  logic [1:0]      sel_val,
  input  logic            hse_mon_en,
  input  logic            lse_mon_set,
  input  logic            hse_irq_clr,
  input  logic            lse_irq_clr,
  output logic [NSRC-1:0] osc_en,
  output logic [1:0]      sel_status,
  output logic            sys_clk,
  output logic            hse_fail_irq,
  output logic            lse_fail_irq,
  output logic            fail_brk,
  output logic            lse_mon_on
);
  localparam logic [NSRC-1:0] EN_RESET = src_bit(SRC_HSI);

  src_e            tgt, cur, go;
  logic [NSRC-1:0] eff_rdy, req_q, keep, en_nxt;
  logic [NSRC-1:0] src_clk, clr, want, gate, gclk;
  logic [NSRC-1:0] gs1, gs2;
  logic            hsisys_clk;
  logic            hse_fail_ev, lse_fail_ev;

  // ---------------- selection control ----------------
  assign eff_rdy = osc_rdy & osc_en;
  assign go      = eff_rdy[tgt] ? tgt : cur;
  assign keep    = src_bit(cur) | src_bit(go);

  always_comb begin
    en_nxt = (osc_en | osc_on) & ~(osc_off & ~keep);
    if (hse_fail_ev) begin
      en_nxt[SRC_HSE] = 1'b0;
      en_nxt[SRC_HSI] = 1'b1;
    end
    if (lse_fail_ev) begin
      en_nxt[SRC_LSE] = 1'b0;
      en_nxt[SRC_LSI] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt          <= SRC_HSI;
      cur          <= SRC_HSI;
      req_q        <= '0;
      osc_en       <= EN_RESET;
      gs1          <= '0;
      gs2          <= '0;
      hse_fail_irq <= 1'b0;
      lse_fail_irq <= 1'b0;
      fail_brk     <= 1'b0;
      lse_mon_on   <= 1'b0;
    end else begin
      osc_en <= en_nxt;
      req_q  <= src_bit(go);
      gs1    <= gate;
      gs2    <= gs1;
      if (gs2 == src_bit(go)) cur <= go;

      if (hse_fail_ev && (tgt == SRC_HSE || cur == SRC_HSE)) tgt <= SRC_HSI;
      else if (lse_fail_ev && (tgt == SRC_LSE || cur == SRC_LSE)) tgt <= SRC_LSI;
      else if (sel_wr) tgt <= src_e'(sel_val);

      fail_brk <= hse_fail_ev;
      if (hse_fail_ev)      hse_fail_irq <= 1'b1;
      else if (hse_irq_clr) hse_fail_irq <= 1'b0;
      if (lse_fail_ev)      lse_fail_irq <= 1'b1;
      else if (lse_irq_clr) lse_fail_irq <= 1'b0;
      if (lse_fail_ev)      lse_mon_on <= 1'b0;
      else if (lse_mon_set) lse_mon_on <= 1'b1;
    end
  end

  assign sel_status = cur;

  // ---------------- clock sources and gating ----------------
  assign clr = {NSRC{rst}} | ~osc_en;

  clk_div_pow2 #(.DIV(HSI_DIV)) u_hsi_div (
    .clk_in (hsi_clk),
    .clr    (clr[SRC_HSI]),
    .clk_out(hsisys_clk)
  );

  assign src_clk = {hse_clk, hsisys_clk, lse_clk, lsi_clk};

  for (genvar i = 0; i < NSRC; i++) begin : g_cell
    localparam logic [NSRC-1:0] SELF = {{(NSRC-1){1'b0}}, 1'b1} << i;
    assign want[i] = req_q[i] & ~|(gate & ~SELF);
    clk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_src(src_clk[i]),
      .clr    (clr[i]),
      .want   (want[i]),
      .gate   (gate[i]),
      .clk_out(gclk[i])
    );
  end

  assign sys_clk = |gclk;

  // ---------------- failure monitors ----------------
  clk_fail_mon #(.WIN(FAIL_WIN), .SYNC_STAGES(SYNC_STAGES)) u_hse_mon (
    .clk    (clk),
    .rst    (rst),
    .mon_clk(hse_clk),
    .mon_clr(clr[SRC_HSE]),
    .arm    (hse_mon_en & osc_en[SRC_HSE] & osc_rdy[SRC_HSE]),
    .fail   (hse_fail_ev)
  );

  clk_fail_mon #(.WIN(FAIL_WIN), .SYNC_STAGES(SYNC_STAGES)) u_lse_mon (
    .clk    (clk),
    .rst    (rst),
    .mon_clk(lse_clk),
    .mon_clr(clr[SRC_LSE]),
    .arm    (lse_mon_on & osc_en[SRC_LSE] & osc_rdy[SRC_LSE]),
    .fail   (lse_fail_ev)
  );
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] osc_en,
  input logic [1:0] sel_status,
  input logic       fail_brk,
  input logic       hse_fail_irq,
  input logic       hse_irq_clr,
  input logic       lse_fail_irq,
  input logic       lse_irq_clr,
  input logic       lse_mon_on,
  input logic       hse_fail_ev,
  input logic       lse_fail_ev
);
  // R4
  active_src_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!hse_fail_ev && !lse_fail_ev && osc_en[sel_status]) |=> osc_en[$past(sel_status)]);

  // R6
  brk_single_chk: assert property (@(posedge clk) disable iff (rst)
    fail_brk |=> !fail_brk);

  // R6
  brk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fail_brk |-> $past(hse_fail_ev));

  // R6
  hse_off_after_fail_chk: assert property (@(posedge clk) disable iff (rst)
    hse_fail_ev |=> !osc_en[3]);

  // R7
  hse_irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (hse_fail_irq && !hse_irq_clr) |=> hse_fail_irq);

  // R8
  lse_irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (lse_fail_irq && !lse_irq_clr) |=> lse_fail_irq);

  // R9
  lse_mon_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lse_mon_on && !lse_fail_ev) |=> lse_mon_on);
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .osc_en      (osc_en),
  .sel_status  (sel_status),
  .fail_brk    (fail_brk),
  .hse_fail_irq(hse_fail_irq),
  .hse_irq_clr (hse_irq_clr),
  .lse_fail_irq(lse_fail_irq),
  .lse_irq_clr (lse_irq_clr),
  .lse_mon_on  (lse_mon_on),
  .hse_fail_ev (hse_fail_ev),
  .lse_fail_ev (lse_fail_ev)
);

// File: tb/sysclk_switch_bench.sv
`timescale 1ns/1ps
module sysclk_switch_bench;
  logic       clk = 1'b0, rst = 1'b1;
  logic       lsi_clk = 1'b0, lse_clk = 1'b0, hsi_clk = 1'b0, hse_clk = 1'b0;
  logic       lsi_run = 1'b1, lse_run = 1'b1, hsi_run = 1'b1, hse_run = 1'b1;
  logic [3:0] osc_rdy = 4'b0100, osc_on = 4'b0, osc_off = 4'b0;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_val = 2'd0;
  logic       hse_mon_en = 1'b0, lse_mon_set = 1'b0, hse_irq_clr = 1'b0, lse_irq_clr = 1'b0;
  logic [3:0] osc_en;
  logic [1:0] sel_status;
  logic       sys_clk, hse_fail_irq, lse_fail_irq, fail_brk, lse_mon_on;

  int checks = 0, errors = 0, brk_count = 0;
  int exp_cur = 2;

  always #5  clk = ~clk;
  always #20 lsi_clk = lsi_run ? ~lsi_clk : lsi_clk;
  always #25 lse_clk = lse_run ? ~lse_clk : lse_clk;
  always #2  hsi_clk = hsi_run ? ~hsi_clk : hsi_clk;
  always #7  hse_clk = hse_run ? ~hse_clk : hse_clk;

  always @(negedge clk) if (!rst && fail_brk) brk_count++;

  sysclk_switch u_sysclk_switch (
    .clk(clk), .rst(rst),
    .lsi_clk(lsi_clk), .lse_clk(lse_clk), .hsi_clk(hsi_clk), .hse_clk(hse_clk),
    .osc_rdy(osc_rdy), .osc_on(osc_on), .osc_off(osc_off),
    .sel_wr(sel_wr), .sel_val(sel_val),
    .hse_mon_en(hse_mon_en), .lse_mon_set(lse_mon_set),
    .hse_irq_clr(hse_irq_clr), .lse_irq_clr(lse_irq_clr),
    .osc_en(osc_en), .sel_status(sel_status), .sys_clk(sys_clk),
    .hse_fail_irq(hse_fail_irq), .lse_fail_irq(lse_fail_irq),
    .fail_brk(fail_brk), .lse_mon_on(lse_mon_on)
  );

  // expected system clock period per source code, in ns
  function automatic int exp_period(input int src);
    case (src)
      0: return 40;
      1: return 50;
      2: return 16;
      default: return 14;
    endcase
  endfunction

  function automatic int exp_sel(input int prev, input int target, input bit ready);
    return ready ? target : prev;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select(input int s);
    @(negedge clk); sel_wr = 1'b1; sel_val = 2'(s);
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic pulse_on(input logic [3:0] v);
    @(negedge clk); osc_on = v;
    @(negedge clk); osc_on = 4'b0;
  endtask

  task automatic pulse_off(input logic [3:0] v);
    @(negedge clk); osc_off = v;
    @(negedge clk); osc_off = 4'b0;
  endtask

  task automatic check_period(input string req, input int src);
    realtime t0, t1;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); t1 = $realtime;
    check(req, int'(t1 - t0), exp_period(src));
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run incomplete, actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    cycles(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 status", sel_status, 2);
    check("R1 osc_en", osc_en, 4'b0100);
    check("R1 irqs", {hse_fail_irq, lse_fail_irq, lse_mon_on}, 0);
    cycles(40);
    check_period("R1 hsisys period", 2);

    pulse_on(4'b1111);
    check("R4 enable all", osc_en, 4'b1111);

    // R3 deferred switch
    select(1);
    cycles(60);
    check("R3 hold while not ready", sel_status, 2);
    check_period("R3 hold period", 2);
    osc_rdy[1] = 1'b1;
    cycles(60);
    check("R3 completes on ready", sel_status, 1);
    check_period("R3 new period", 1);
    exp_cur = 1;
    osc_rdy = 4'b1111;

    // R2 randomized switching
    for (int k = 0; k < 12; k++) begin
      int t;
      bit r;
      t = int'($urandom % 4);
      r = 1'($urandom % 2);
      @(negedge clk); osc_rdy[t] = r;
      select(t);
      cycles(60);
      exp_cur = exp_sel(exp_cur, t, r);
      check(r ? "R2 switch" : "R3 wait", sel_status, exp_cur);
      check_period("R2 period", exp_cur);
      osc_rdy[t] = 1'b1;
      cycles(60);
      exp_cur = t;
      check("R3 late switch", sel_status, exp_cur);
    end

    // R4 protection of active source
    select(2);
    cycles(60);
    pulse_off(4'b0100);
    check("R4 active kept", osc_en[2], 1);
    check_period("R4 still running", 2);
    pulse_off(4'b0001);
    check("R4 idle off", osc_en[0], 0);
    pulse_on(4'b0001);

    // R5 / R6 high-speed crystal failure
    select(3);
    cycles(60);
    check("R2 hse active", sel_status, 3);
    check_period("R2 hse period", 3);
    @(negedge clk); hse_run = 1'b0;
    cycles(40);
    check("R5 disarmed no irq", hse_fail_irq, 0);
    check("R5 disarmed stays", sel_status, 3);
    @(negedge clk); hse_mon_en = 1'b1;
    cycles(40);
    check("R6 irq set", hse_fail_irq, 1);
    check("R6 hse disabled", osc_en[3], 0);
    check("R6 one break pulse", brk_count, 1);
    cycles(60);
    check("R6 fallback", sel_status, 2);
    check_period("R6 fallback period", 2);

    // R7 sticky interrupt
    cycles(20);
    check("R7 still pending", hse_fail_irq, 1);
    @(negedge clk); hse_irq_clr = 1'b1;
    @(negedge clk); hse_irq_clr = 1'b0;
    check("R7 cleared", hse_fail_irq, 0);

    // R5 armed with running crystal: no false failure
    hse_run = 1'b1;
    pulse_on(4'b1000);
    select(3);
    cycles(100);
    check("R5 armed no false fail", hse_fail_irq, 0);
    check("R5 hse in use", sel_status, 3);
    @(negedge clk); hse_mon_en = 1'b0;
    select(2);
    cycles(60);

    // R8 / R9 low-speed crystal failure
    select(1);
    cycles(60);
    check("R2 lse active", sel_status, 1);
    @(negedge clk); lse_mon_set = 1'b1;
    @(negedge clk); lse_mon_set = 1'b0;
    check("R9 monitor set", lse_mon_on, 1);
    pulse_off(4'b0001);
    cycles(50);
    check("R9 monitor holds", lse_mon_on, 1);
    check("R8 no false fail", lse_fail_irq, 0);
    @(negedge clk); lse_run = 1'b0;
    cycles(40);
    check("R8 irq set", lse_fail_irq, 1);
    check("R9 monitor cleared by failure", lse_mon_on, 0);
    check("R8 lse disabled", osc_en[1], 0);
    cycles(60);
    check("R8 fallback", sel_status, 0);
    check_period("R8 fallback period", 0);
    check("R8 no break pulse", brk_count, 1);
    cycles(10);
    check("R8 still pending", lse_fail_irq, 1);
    @(negedge clk); lse_irq_clr = 1'b1;
    @(negedge clk); lse_irq_clr = 1'b0;
    check("R8 cleared", lse_fail_irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule